// File: doc/BRIEF.md
# Low-Level Input Squelch Detector

This block gates quiet input noise out of a PCM audio stream before any gain stage has a chance to amplify it. Each valid signed 16-bit sample has its magnitude compared against an 8-bit programmable threshold. Once the magnitude has stayed under the threshold for a run of consecutive samples (HOLD_SAMPLES, 200 by default, which is 25 ms at 8 kHz), the block puts zero on its output in place of the input.

The gate opens again on the first sample whose magnitude is at or above the threshold, and that sample passes through unmodified. Every valid input sample produces exactly one output sample, registered one cycle later. A flag on the output reports whether the gate is engaged.

Top module: `squelch_gate`

## Requirements
- R1: After reset, out_valid is 0, out_sample is 0, squelch_on is 0 and the quiet-run count is zero.
- R2: Each in_valid cycle produces out_valid high on the next clock cycle, with the output for that sample. out_valid is low on every other cycle.
- R3: The magnitude is the absolute value of the sample, and -32768 saturates to 32767. The magnitude is compared with the threshold zero-extended to 16 bits. A sample is quiet when its magnitude is strictly less than the threshold.
- R4: A sample is zeroed, with squelch_on high on its output, only when it is quiet and is at least the HOLD_SAMPLES-th consecutive quiet valid sample. With the default of 200, sample 199 of a quiet run passes and sample 200 is zeroed.
- R5: A sample at or above the threshold resets the quiet run. It passes unmodified with squelch_on low, even while the gate is engaged.
- R6: Cycles without in_valid neither advance nor reset the quiet run.
- R7: With threshold 0 no sample is quiet, so every sample passes. With threshold 0xFF, a magnitude of 0xFE is quiet and 0xFF is not.
- R8: The quiet-run counter saturates, so a quiet run of any length keeps the gate engaged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sample | input | 16 | Signed PCM input sample |
| in_valid | input | 1 | Input sample strobe |
| threshold | input | 8 | Quiet threshold (software default 0x1F) |
| out_sample | output | 16 | Gated sample |
| out_valid | output | 1 | Output strobe |
| squelch_on | output | 1 | High while the output sample was zeroed |

## Verification
The hardest situation to reach from the ports is the exact boundary of the hold window. That boundary has to be seen together with idle cycles placed inside a quiet run, and with a loud sample arriving while the gate is already engaged.

The bench feeds runs of exactly HOLD_SAMPLES-1 and HOLD_SAMPLES quiet samples, with gaps between them, and checks the zeroing sample by sample. It then breaks an engaged gate with a single at-threshold sample and checks that the count starts again from zero.

// File: rtl/squelch_gate.sv
module squelch_gate #(
  parameter int SAMPLE_W     = 16,
  parameter int THRESH_W     = 8,
  parameter int HOLD_SAMPLES = 200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                in_valid,
  input  logic [THRESH_W-1:0] threshold,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic                out_valid,
  output logic                squelch_on
);
  localparam int CNT_W = $clog2(HOLD_SAMPLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_SAMPLES);
  localparam logic [SAMPLE_W-1:0] MIN_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [CNT_W-1:0]    run_cnt;
  logic [SAMPLE_W-1:0] mag;
  logic                quiet;
  logic [CNT_W-1:0]    run_next;
  logic                gate;

  assign mag = !in_sample[SAMPLE_W-1] ? in_sample :
               (in_sample == MIN_NEG) ? ~MIN_NEG : (~in_sample + 1'b1);
  assign quiet    = mag < SAMPLE_W'(threshold);
  assign run_next = !quiet ? '0 : (run_cnt == CNT_MAX) ? run_cnt : run_cnt + 1'b1;
  assign gate     = quiet && (run_next == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt    <= '0;
      out_sample <= '0;
      out_valid  <= 1'b0;
      squelch_on <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        run_cnt    <= run_next;
        out_sample <= gate ? '0 : in_sample;
        squelch_on <= gate;
      end
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_no_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_zero_when_squelched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    squelch_on |-> out_sample == '0);
  assert_loud_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !quiet) |=> (!squelch_on && out_sample == $past(in_sample)));
  assert_idle_holds_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(run_cnt));
  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_MAX);
endmodule

// File: tb/squelch_gate_tb.sv
module squelch_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] in_sample = '0;
  logic in_valid = 1'b0;
  logic [7:0] threshold = 8'h1F;
  logic [15:0] out_sample;
  logic out_valid, squelch_on;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  squelch_gate dut_i (.clk(clk), .rst_n(rst_n), .in_sample(in_sample), .in_valid(in_valid),
    .threshold(threshold), .out_sample(out_sample), .out_valid(out_valid), .squelch_on(squelch_on));

  task automatic chk(input string req, input logic [15:0] got_s, input logic got_q,
                     input logic [15:0] exp_s, input logic exp_q);
    n_run++;
    if (got_s !== exp_s || got_q !== exp_q) begin
      n_fail++;
      $display("FAIL %s: sample=%h squelch=%b expected sample=%h squelch=%b", req, got_s, got_q, exp_s, exp_q);
    end
  endtask

  // drive one sample, sample outputs at the following negedge
  task automatic send(input logic [15:0] s, input string req, input logic [15:0] exp_s,
                      input logic exp_q, input bit do_chk);
    in_sample = s; in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    if (do_chk) begin
      n_run++;
      if (out_valid !== 1'b1) begin n_fail++; $display("FAIL R2: out_valid=%b expected 1", out_valid); end
      chk(req, out_sample, squelch_on, exp_s, exp_q);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R1", out_sample, squelch_on, 16'h0, 1'b0);
    n_run++;
    if (out_valid !== 1'b0) begin n_fail++; $display("FAIL R1: out_valid=%b expected 0", out_valid); end
  endtask

  task automatic t_boundary();
    reset_dut(); threshold = 8'h1F;
    for (int i = 1; i < 200; i++) send(16'h0005, "R4", 16'h0005, 1'b0, i == 199);
    send(16'hFFF0, "R4", 16'h0000, 1'b1, 1);
    send(16'h0003, "R8", 16'h0000, 1'b1, 1);
    @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0) begin n_fail++; $display("FAIL R2: idle out_valid=%b expected 0", out_valid); end
  endtask

  task automatic t_release();
    send(16'h001F, "R5", 16'h001F, 1'b0, 1);
    send(16'h0001, "R5", 16'h0001, 1'b0, 1);
    send(16'hFFE1, "R3", 16'hFFE1, 1'b0, 1);
  endtask

  task automatic t_gaps();
    reset_dut(); threshold = 8'h1F;
    for (int i = 1; i < 200; i++) begin
      send(16'hFFFF, "R6", 16'hFFFF, 1'b0, i == 199);
      if (i % 50 == 0) repeat (3) @(negedge clk);
    end
    send(16'h0000, "R6", 16'h0000, 1'b1, 1);
  endtask

  task automatic t_long();
    for (int i = 0; i < 300; i++) send(16'h0002, "R8", 16'h0000, 1'b1, i == 299);
  endtask

  task automatic t_edges();
    reset_dut(); threshold = 8'h00;
    for (int i = 0; i < 210; i++) send(16'h0000, "R7", 16'h0000, 1'b0, i == 209);
    reset_dut(); threshold = 8'hFF;
    for (int i = 0; i < 199; i++) send(16'h00FE, "R7", 16'h00FE, 1'b0, 0);
    send(16'h00FE, "R7", 16'h0000, 1'b1, 1);
    send(16'hFF01, "R7", 16'hFF01, 1'b0, 1);
    reset_dut(); threshold = 8'hFF;
    for (int i = 0; i < 199; i++) send(16'h00FE, "R3", 16'h00FE, 1'b0, 0);
    send(16'h8000, "R3", 16'h8000, 1'b0, 1);
  endtask

  initial begin
    t_reset();
    t_boundary();
    t_release();
    t_gaps();
    t_long();
    t_edges();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule